// File: doc/BRIEF.md
# In-Order Memory Completion Buffer

This block sits between a memory instruction issue queue and the memory system of a vector compute unit. Each cycle it may dispatch the request at the head of the issue queue. A request carries a 6-bit sequence tag and one of four kinds: load, store, atomic or memory sync. At dispatch the block takes one coalescer credit and records the request in a 16-entry circular buffer as "pending". Memory responses may come back in any order and are matched by tag, which marks the entry finished. Retirement runs strictly oldest-first. The oldest entry leaves the block only when it is finished, the memory-to-register bus is idle and, for loads and atomics, the register file can accept the write.

Reads (loads and atomics) and stores are throttled against separate in-flight counters that share one limit. A sync that closes a kernel is dispatched but never tracked. A request whose active-lane mask is empty gives its credit back at once, unless it is a sync. Each retirement holds the return bus for a fixed number of cycles.

Top module: `inorder_resp_buffer`

## Requirements
- R1: Entries retire on `ret_valid` in dispatch order, whatever order their responses arrive in. `ret_tag` carries the tag given at dispatch.
- R2: While the oldest entry has no response, no entry retires, even if younger entries are finished.
- R3: A load (`iss_type`=0) or atomic (`iss_type`=2) cannot dispatch (`iss_ready`=0) while QSIZE reads are in flight. Stores are not held back by the read count.
- R4: A store (`iss_type`=1) cannot dispatch while QSIZE stores are in flight.
- R5: No request dispatches while `cred_avail` is 0. Each dispatch pulses `cred_take` in that cycle.
- R6: A dispatched non-sync request with `iss_lanes_zero`=1 raises `cred_ret` in the same cycle. A sync (`iss_type`=3) never raises it.
- R7: A sync with `iss_eok`=1 dispatches without taking a buffer entry. It never retires, and it can dispatch while the buffer is full.
- R8: Retiring a read frees its in-flight slot, so a stalled load can dispatch afterwards.
- R9: After a retirement, the next one comes no earlier than OCC cycles later. With a backlog of finished entries, retirements are exactly OCC cycles apart.
- R10: A finished load or atomic at the head waits while `rf_ok` is 0. A store at the head retires regardless of `rf_ok`.
- R11: When all 16 entries are in use, a request that needs an entry is not dispatched and `ovf` is 1 while it is presented.
- R12: `rsp_err` is 1 during a response whose tag matches no held entry.
- R13: After reset the buffer is empty, both counters are zero, `ret_valid`, `ovf` and `rsp_err` are 0, and a request with a credit is ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| iss_valid | input | 1 | Issue queue head is valid |
| iss_type | input | 2 | 0 load, 1 store, 2 atomic, 3 sync |
| iss_tag | input | 6 | Sequence tag of the head request |
| iss_eok | input | 1 | Sync marks end of kernel |
| iss_lanes_zero | input | 1 | Active-lane mask is empty |
| iss_ready | output | 1 | Head request may dispatch this cycle |
| cred_avail | input | 1 | At least one coalescer credit free |
| cred_take | output | 1 | One credit consumed |
| cred_ret | output | 1 | One credit given back |
| rsp_valid | input | 1 | Memory response present |
| rsp_tag | input | 6 | Tag of the response |
| rsp_err | output | 1 | Response matches no entry |
| rf_ok | input | 1 | Register file can take load data |
| ret_valid | output | 1 | Oldest entry retires this cycle |
| ret_tag | output | 6 | Tag of the retiring entry |
| ret_type | output | 2 | Kind of the retiring entry |
| ovf | output | 1 | Allocation attempted while full |

## Verification
The bench returns responses in reverse order. A design that retired on response arrival, or let a finished younger entry pass an unfinished head, would log the tags out of order. It fills each in-flight counter to its limit and then offers the other kind of request. A shared or swapped counter would stall the wrong kind, or fail to free a slot on retirement. It fills the buffer with syncs and then offers an end-of-kernel sync, which must still pass while a plain sync stalls with `ovf`. It checks that retirements are exactly OCC cycles apart and that a store at the head ignores `rf_ok`, which catches a bus hold that is off by one and a register-file gate applied to the wrong kind.

// File: rtl/inorder_resp_buffer.sv
module inorder_resp_buffer #(
  parameter int TAG_W = 6,
  parameter int DEPTH = 16,
  parameter int QSIZE = 4,
  parameter int OCC   = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             iss_valid,
  input  logic [1:0]       iss_type,
  input  logic [TAG_W-1:0] iss_tag,
  input  logic             iss_eok,
  input  logic             iss_lanes_zero,
  output logic             iss_ready,
  input  logic             cred_avail,
  output logic             cred_take,
  output logic             cred_ret,
  input  logic             rsp_valid,
  input  logic [TAG_W-1:0] rsp_tag,
  output logic             rsp_err,
  input  logic             rf_ok,
  output logic             ret_valid,
  output logic [TAG_W-1:0] ret_tag,
  output logic [1:0]       ret_type,
  output logic             ovf
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam int QC_W  = $clog2(QSIZE + 1);
  localparam int OCC_W = $clog2(OCC + 1);
  localparam logic [1:0] K_LD = 2'd0, K_ST = 2'd1, K_AT = 2'd2, K_SY = 2'd3;

  logic [DEPTH-1:0] e_vld, e_done, hit;
  logic [TAG_W-1:0] e_tag [DEPTH];
  logic [1:0]       e_typ [DEPTH];
  logic [PTR_W-1:0] head, tail;
  logic [CNT_W-1:0] count;
  logic [QC_W-1:0]  rd_cnt, st_cnt;
  logic [OCC_W-1:0] bus_cnt;

  wire iss_rd  = (iss_type == K_LD) || (iss_type == K_AT);
  wire iss_st  = (iss_type == K_ST);
  wire need_e  = !((iss_type == K_SY) && iss_eok);
  wire full    = (count == CNT_W'(DEPTH));
  wire rd_stop = iss_rd && (rd_cnt >= QC_W'(QSIZE));
  wire st_stop = iss_st && (st_cnt >= QC_W'(QSIZE));

  assign iss_ready = cred_avail && !rd_stop && !st_stop && !(need_e && full);
  wire   fire      = iss_valid && iss_ready;
  wire   alloc     = fire && need_e;
  assign cred_take = fire;
  assign cred_ret  = fire && iss_lanes_zero && (iss_type != K_SY);
  assign ovf       = iss_valid && need_e && full;

  genvar gi;
  generate
    for (gi = 0; gi < DEPTH; gi++) begin : g_match
      assign hit[gi] = e_vld[gi] && (e_tag[gi] == rsp_tag);
    end
  endgenerate
  assign rsp_err = rsp_valid && (hit == '0);

  wire head_rd = (e_typ[head] == K_LD) || (e_typ[head] == K_AT);
  wire head_st = (e_typ[head] == K_ST);
  assign ret_valid = e_vld[head] && e_done[head] && (bus_cnt == '0) && (!head_rd || rf_ok);
  assign ret_tag   = e_tag[head];
  assign ret_type  = e_typ[head];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      e_vld   <= '0;
      e_done  <= '0;
      for (int i = 0; i < DEPTH; i++) begin
        e_tag[i] <= '0;
        e_typ[i] <= '0;
      end
      head    <= '0;
      tail    <= '0;
      count   <= '0;
      rd_cnt  <= '0;
      st_cnt  <= '0;
      bus_cnt <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++)
        if (rsp_valid && hit[i]) e_done[i] <= 1'b1;
      if (ret_valid) begin
        e_vld[head] <= 1'b0;
        head        <= nxt(head);
      end
      if (alloc) begin
        e_vld[tail]  <= 1'b1;
        e_done[tail] <= 1'b0;
        e_tag[tail]  <= iss_tag;
        e_typ[tail]  <= iss_type;
        tail         <= nxt(tail);
      end
      count  <= count + CNT_W'(alloc) - CNT_W'(ret_valid);
      rd_cnt <= rd_cnt + QC_W'(fire && iss_rd) - QC_W'(ret_valid && head_rd);
      st_cnt <= st_cnt + QC_W'(fire && iss_st) - QC_W'(ret_valid && head_st);
      if (ret_valid)           bus_cnt <= OCC_W'(OCC - 1);
      else if (bus_cnt != '0)  bus_cnt <= bus_cnt - 1'b1;
    end
  end

  assert_rd_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_cnt) <= QSIZE);
  assert_st_cap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    int'(st_cnt) <= QSIZE);
  assert_inflight_tracked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd_cnt) + int'(st_cnt) <= int'(count));
  assert_bus_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (OCC > 1 && ret_valid) |=> !ret_valid);
  assert_retire_frees_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_valid && !alloc) |=> (count == $past(count) - 1'b1));
  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |-> !fire);
endmodule

// File: tb/inorder_resp_buffer_tb.sv
module inorder_resp_buffer_tb_top;
  localparam int CLK_P = 10;
  localparam int OCC   = 3;
  localparam logic [1:0] LD = 2'd0, ST = 2'd1, AT = 2'd2, SY = 2'd3;

  logic clk = 0, rst_n = 0;
  logic iss_valid = 0, iss_eok = 0, iss_lz = 0, cred_avail = 1, rsp_valid = 0, rf_ok = 1;
  logic [1:0] iss_type = 0;
  logic [5:0] iss_tag = 0, rsp_tag = 0;
  logic iss_ready, cred_take, cred_ret, rsp_err, ret_valid, ovf;
  logic [5:0] ret_tag;
  logic [1:0] ret_type;

  int tests = 0, fails = 0, cyc = 0, rn = 0;
  int rlog_tag [64];
  int rlog_cyc [64];

  inorder_resp_buffer #(.OCC(OCC)) dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_type(iss_type), .iss_tag(iss_tag),
    .iss_eok(iss_eok), .iss_lanes_zero(iss_lz), .iss_ready(iss_ready), .cred_avail(cred_avail),
    .cred_take(cred_take), .cred_ret(cred_ret), .rsp_valid(rsp_valid), .rsp_tag(rsp_tag),
    .rsp_err(rsp_err), .rf_ok(rf_ok), .ret_valid(ret_valid), .ret_tag(ret_tag),
    .ret_type(ret_type), .ovf(ovf));

  always #(CLK_P/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (rst_n && ret_valid && rn < 64) begin
    rlog_tag[rn] = int'(ret_tag);
    rlog_cyc[rn] = cyc;
    rn++;
  end

  task automatic chk(input int act, input int exp, input string req);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic disp(input logic [1:0] t, input int g, input bit eok, input bit lz,
                      input bit exp_rdy, input bit exp_cr, input bit exp_ovf, input string req);
    @(posedge clk); #1;
    iss_valid = 1; iss_type = t; iss_tag = 6'(g); iss_eok = eok; iss_lz = lz;
    @(negedge clk);
    chk(int'(iss_ready), int'(exp_rdy), req);
    chk(int'(cred_take), int'(exp_rdy), req);
    chk(int'(ovf), int'(exp_ovf), req);
    if (exp_rdy) chk(int'(cred_ret), int'(exp_cr), req);
    @(posedge clk); #1;
    iss_valid = 0; iss_eok = 0; iss_lz = 0;
  endtask

  task automatic respond(input int g, input bit exp_err, input string req);
    @(posedge clk); #1;
    rsp_valid = 1; rsp_tag = 6'(g);
    @(negedge clk);
    chk(int'(rsp_err), int'(exp_err), req);
    @(posedge clk); #1;
    rsp_valid = 0;
  endtask

  task automatic set_rf(input bit v);
    @(posedge clk); #1; rf_ok = v;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk(int'(ret_valid), 0, "R13 ret_valid");
    chk(int'(ovf), 0, "R13 ovf");
    chk(int'(rsp_err), 0, "R13 rsp_err");
    chk(int'(iss_ready), 1, "R13 ready");
  endtask

  task automatic t_order;
    rn = 0;
    disp(LD, 1, 0, 0, 1, 0, 0, "R1 dispatch");
    disp(LD, 2, 0, 0, 1, 0, 0, "R1 dispatch");
    disp(LD, 3, 0, 0, 1, 0, 0, "R1 dispatch");
    respond(3, 0, "R1 rsp");
    respond(2, 0, "R1 rsp");
    idle(5);
    chk(rn, 0, "R2 younger done waits");
    respond(1, 0, "R1 rsp");
    idle(15);
    chk(rn, 3, "R1 retire count");
    for (int i = 0; i < 3; i++) chk(rlog_tag[i], i + 1, "R1 order");
    chk(rlog_cyc[1] - rlog_cyc[0], OCC, "R9 gap");
    chk(rlog_cyc[2] - rlog_cyc[1], OCC, "R9 gap");
  endtask

  task automatic t_limits;
    int expv [9] = '{10, 11, 12, 13, 20, 21, 22, 23, 14};
    rn = 0;
    set_rf(0);
    disp(LD, 10, 0, 0, 1, 0, 0, "R3 fill");
    disp(LD, 11, 0, 0, 1, 0, 0, "R3 fill");
    disp(LD, 12, 0, 0, 1, 0, 0, "R3 fill");
    disp(AT, 13, 0, 0, 1, 0, 0, "R3 fill");
    disp(LD, 14, 0, 0, 0, 0, 0, "R3 load stalls at limit");
    disp(AT, 15, 0, 0, 0, 0, 0, "R3 atomic stalls at limit");
    disp(ST, 20, 0, 0, 1, 0, 0, "R3 store unaffected");
    disp(ST, 21, 0, 0, 1, 0, 0, "R4 fill");
    disp(ST, 22, 0, 0, 1, 0, 0, "R4 fill");
    disp(ST, 23, 0, 0, 1, 0, 0, "R4 fill");
    disp(ST, 24, 0, 0, 0, 0, 0, "R4 store stalls at limit");
    respond(10, 0, "R10 rsp");
    idle(5);
    chk(rn, 0, "R10 load held by rf_ok");
    set_rf(1);
    idle(2);
    chk(rn, 1, "R10 load retires with rf_ok");
    disp(LD, 14, 0, 0, 1, 0, 0, "R8 slot freed");
    respond(11, 0, "R8 rsp");
    respond(12, 0, "R8 rsp");
    respond(13, 0, "R8 rsp");
    idle(12);
    set_rf(0);
    respond(20, 0, "R10 rsp");
    idle(5);
    chk(rn, 5, "R10 store ignores rf_ok");
    respond(21, 0, "R1 rsp");
    respond(22, 0, "R1 rsp");
    respond(23, 0, "R1 rsp");
    respond(14, 0, "R1 rsp");
    set_rf(1);
    idle(20);
    chk(rn, 9, "R1 drain");
    for (int i = 0; i < 9; i++) chk(rlog_tag[i], expv[i], "R1 order");
  endtask

  task automatic t_credit;
    rn = 0;
    cred_avail = 0;
    disp(LD, 30, 0, 0, 0, 0, 0, "R5 no credit");
    cred_avail = 1;
    disp(LD, 30, 0, 1, 1, 1, 0, "R6 empty lanes return");
    disp(SY, 31, 0, 1, 1, 0, 0, "R6 sync keeps credit");
    disp(SY, 32, 1, 1, 1, 0, 0, "R7 end of kernel");
    respond(30, 0, "R7 rsp");
    respond(31, 0, "R7 rsp");
    idle(10);
    chk(rn, 2, "R7 no entry for end of kernel");
    chk(rlog_tag[0], 30, "R7 order");
    chk(rlog_tag[1], 31, "R7 order");
    respond(32, 1, "R7 untracked tag");
    respond(50, 1, "R12 unknown tag");
  endtask

  task automatic t_full;
    rn = 0;
    for (int i = 0; i < 16; i++) disp(SY, i, 0, 0, 1, 0, 0, "R11 fill");
    disp(SY, 16, 0, 0, 0, 0, 1, "R11 full stalls");
    disp(SY, 17, 1, 0, 1, 0, 0, "R7 eok while full");
    for (int i = 0; i < 16; i++) respond(i, 0, "R11 rsp");
    idle(60);
    chk(rn, 16, "R11 drain");
    chk(rlog_tag[15], 15, "R11 last");
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests + 1, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    t_reset();
    t_order();
    t_limits();
    t_credit();
    t_full();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule